// File: doc/BRIEF.md
# Watchdog Timer with Postscaler

This block is a watchdog that counts on its own free-running clock, separate from the system clock. It counts a base period of watchdog-clock cycles. A programmable postscaler can stretch that period by a power of two from 1 to 128. Software must strobe a clear before the period runs out. If it does not, the block raises a one-cycle reset request toward the system. If the core is asleep when the period runs out, the block raises a wake request instead of a reset.

Entering sleep zeroes the count in the same way as a clear does. An active-low status flag drops whenever a timeout happens and is set again by a clear or a sleep-entry strobe. The block reads a configuration enable bit only while it leaves power-on reset. If that bit is low at that moment, the watchdog stays off until the next power-on reset. Signals cross between the two clock domains through synchronizers in both directions.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, rst_req and wake_req are 0 and to_n is 1.
- R2: With ps_assign at 0, a timeout occurs BASE_CYC watchdog-clock cycles after the last clear, plus synchronizer latency, whatever value ps_ratio holds.
- R3: With ps_assign at 1, the timeout period is BASE_CYC times 2^ps_ratio. Code 3'b000 gives 1:1, 3'b011 gives 1:8 and 3'b111 gives 1:128.
- R4: A clear strobe zeroes both the base counter and the postscaler. Clears that arrive more often than once per period prevent every reset request.
- R5: A timeout while asleep is high raises wake_req and produces no rst_req pulse. wake_req stays high until the next clear or sleep-entry strobe.
- R6: A timeout drives to_n to 0. A clear or sleep-entry strobe drives it back to 1.
- R7: If cfg_en is 0 when power-on reset is released, no timeout ever occurs, even if cfg_en later rises. Only a new power-on reset can re-arm the watchdog.
- R8: The watchdog keeps counting while the system clock is stopped. A timeout that happens in that interval shows up once the system clock resumes.
- R9: After a timeout the counter and postscaler restart from zero, so the next timeout follows one full period later.
- R10: Each rst_req pulse is exactly one system-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Free-running watchdog clock |
| sclk | input | 1 | System clock; may be stopped |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_en | input | 1 | Configuration enable, captured at reset release |
| ps_assign | input | 1 | 1 attaches the postscaler to the watchdog |
| ps_ratio | input | 3 | Postscaler ratio exponent, 2^value |
| clr_stb | input | 1 | Clear-watchdog strobe, one sclk cycle |
| sleep_stb | input | 1 | Sleep-entry strobe, one sclk cycle |
| asleep | input | 1 | High while the core sleeps |
| rst_req | output | 1 | Reset request pulse, sclk domain |
| wake_req | output | 1 | Wake request level, sclk domain |
| to_n | output | 1 | Timeout status, low after a timeout |

## Verification
A strobe needs about three watchdog-clock edges to reach the counter. The count restarts one edge after that. A timeout then needs two system-clock edges plus one edge-detect register before rst_req appears, and two edges before wake_req or to_n change. Every timing check therefore uses two points for a period P. At P watchdog cycles after the strobe, no request may have appeared yet. At P+14 cycles, exactly one must have appeared. That window is shorter than any second period. Status and wake checks are sampled 10 watchdog cycles after a strobe, which is after the crossing completes and before the next timeout.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int unsigned DEF_BASE_CYC = 4608;
    localparam int unsigned DEF_RATIO_W  = 3;

    typedef struct packed {
        logic rprev;
        logic rst;
    } sys_state_t;
endpackage

// File: rtl/wdog_sync2.sv
`timescale 1ns/1ps
module wdog_sync2 #(
    parameter int unsigned WIDTH   = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_a,
    output logic [WIDTH-1:0] q_s
);
    logic [WIDTH-1:0] meta_d, meta_q, out_d, out_q;

    always_comb begin
        meta_d = d_a;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {WIDTH{RST_VAL}};
            out_q  <= {WIDTH{RST_VAL}};
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign q_s = out_q;
endmodule

// File: rtl/wdog_pulse_xfer.sv
`timescale 1ns/1ps
module wdog_pulse_xfer (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic pulse_src,
    output logic pulse_dst
);
    logic       tgl_d, tgl_q;
    logic [2:0] shf_d, shf_q;

    always_comb begin
        tgl_d = tgl_q ^ pulse_src;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_d;
    end

    always_comb begin
        shf_d = {shf_q[1:0], tgl_q};
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign pulse_dst = shf_q[2] ^ shf_q[1];
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
    parameter int unsigned BASE_CYC = wdog_pkg::DEF_BASE_CYC,
    parameter int unsigned RATIO_W  = wdog_pkg::DEF_RATIO_W
) (
    input  logic               wclk,
    input  logic               rst_n,
    input  logic               kick,
    input  logic               cfg_en_a,
    input  logic               ps_assign_a,
    input  logic [RATIO_W-1:0] ps_ratio_a,
    input  logic               asleep_a,
    output logic               to_flag,
    output logic               wake_lvl,
    output logic               rst_tgl
);
    localparam int unsigned CNT_W = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;
    localparam int unsigned PS_W  = (1 << RATIO_W) - 1;
    localparam int unsigned SY_W  = RATIO_W + 3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PS_W-1:0]  ps;
        logic [1:0]       arm;
        logic             en;
        logic             to;
        logic             wake;
        logic             rtgl;
    } core_state_t;

    core_state_t        st_d, st_q;
    logic [SY_W-1:0]    sy_s;
    logic               cfg_s, assign_s, asleep_s;
    logic [RATIO_W-1:0] ratio_s;
    logic [PS_W-1:0]    ps_lim;
    logic               base_wrap, ps_hit, tmo;

    wdog_sync2 #(.WIDTH(SY_W), .RST_VAL(1'b0)) u_sync (
        .clk  (wclk),
        .rst_n(rst_n),
        .d_a  ({cfg_en_a, ps_assign_a, asleep_a, ps_ratio_a}),
        .q_s  (sy_s)
    );

    assign {cfg_s, assign_s, asleep_s, ratio_s} = sy_s;

    always_comb begin
        ps_lim = '0;
        for (int i = 0; i < PS_W; i++) begin
            if (i < int'(ratio_s)) ps_lim[i] = 1'b1;
        end
    end

    always_comb begin
        st_d      = st_q;
        base_wrap = st_q.en && (st_q.cnt == CNT_W'(BASE_CYC - 1));
        ps_hit    = !assign_s || (st_q.ps >= ps_lim);
        tmo       = base_wrap && ps_hit && !kick;

        if (st_q.arm != 2'd3) st_d.arm = st_q.arm + 2'd1;
        if (st_q.arm == 2'd2) st_d.en  = cfg_s;

        if (kick) begin
            st_d.cnt  = '0;
            st_d.ps   = '0;
            st_d.to   = 1'b1;
            st_d.wake = 1'b0;
        end else if (st_q.en) begin
            if (base_wrap) begin
                st_d.cnt = '0;
                if (ps_hit) begin
                    st_d.ps = '0;
                    st_d.to = 1'b0;
                    if (asleep_s) st_d.wake = 1'b1;
                    else          st_d.rtgl = ~st_q.rtgl;
                end else begin
                    st_d.ps = st_q.ps + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.ps   <= '0;
            st_q.arm  <= '0;
            st_q.en   <= 1'b0;
            st_q.to   <= 1'b1;
            st_q.wake <= 1'b0;
            st_q.rtgl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign to_flag  = st_q.to;
    assign wake_lvl = st_q.wake;
    assign rst_tgl  = st_q.rtgl;

    AST_KICK_ZEROES: assert property (@(posedge wclk) disable iff (!rst_n)
        kick |=> (st_q.cnt == '0) && (st_q.ps == '0) && st_q.to); // R4

    AST_TMO_DROPS_FLAG: assert property (@(posedge wclk) disable iff (!rst_n)
        tmo |=> !st_q.to); // R6

    AST_SLEEP_NO_RESET: assert property (@(posedge wclk) disable iff (!rst_n)
        (tmo && asleep_s) |=> (st_q.wake && $stable(st_q.rtgl))); // R5

    AST_EN_LOCKED: assert property (@(posedge wclk) disable iff (!rst_n)
        (st_q.arm == 2'd3) |=> $stable(st_q.en)); // R7

    AST_OFF_IDLE: assert property (@(posedge wclk) disable iff (!rst_n)
        !st_q.en |=> (st_q.cnt == '0)); // R7

    AST_RESTART_ZERO: assert property (@(posedge wclk) disable iff (!rst_n)
        tmo |=> (st_q.cnt == '0) && (st_q.ps == '0)); // R9

    AST_CNT_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(BASE_CYC - 1)); // R2
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top #(
    parameter int unsigned BASE_CYC = wdog_pkg::DEF_BASE_CYC,
    parameter int unsigned RATIO_W  = wdog_pkg::DEF_RATIO_W
) (
    input  logic               wclk,
    input  logic               sclk,
    input  logic               por_n,
    input  logic               cfg_en,
    input  logic               ps_assign,
    input  logic [RATIO_W-1:0] ps_ratio,
    input  logic               clr_stb,
    input  logic               sleep_stb,
    input  logic               asleep,
    output logic               rst_req,
    output logic               wake_req,
    output logic               to_n
);
    import wdog_pkg::*;

    logic       kick_w, to_w, wake_w, rtgl_w, rtgl_s;
    sys_state_t sy_d, sy_q;

    wdog_pulse_xfer u_kick (
        .src_clk  (sclk),
        .dst_clk  (wclk),
        .rst_n    (por_n),
        .pulse_src(clr_stb | sleep_stb),
        .pulse_dst(kick_w)
    );

    wdog_core #(.BASE_CYC(BASE_CYC), .RATIO_W(RATIO_W)) u_core (
        .wclk       (wclk),
        .rst_n      (por_n),
        .kick       (kick_w),
        .cfg_en_a   (cfg_en),
        .ps_assign_a(ps_assign),
        .ps_ratio_a (ps_ratio),
        .asleep_a   (asleep),
        .to_flag    (to_w),
        .wake_lvl   (wake_w),
        .rst_tgl    (rtgl_w)
    );

    wdog_sync2 #(.WIDTH(1), .RST_VAL(1'b0)) u_rsync (
        .clk(sclk), .rst_n(por_n), .d_a(rtgl_w), .q_s(rtgl_s)
    );

    wdog_sync2 #(.WIDTH(1), .RST_VAL(1'b0)) u_wsync (
        .clk(sclk), .rst_n(por_n), .d_a(wake_w), .q_s(wake_req)
    );

    wdog_sync2 #(.WIDTH(1), .RST_VAL(1'b1)) u_tsync (
        .clk(sclk), .rst_n(por_n), .d_a(to_w), .q_s(to_n)
    );

    always_comb begin
        sy_d.rprev = rtgl_s;
        sy_d.rst   = rtgl_s ^ sy_q.rprev;
    end

    always_ff @(posedge sclk or negedge por_n) begin
        if (!por_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rst_req = sy_q.rst;

    AST_RST_ONE_PULSE: assert property (@(posedge sclk) disable iff (!por_n)
        rst_req |=> !rst_req); // R10

    AST_WAKE_HAS_TMO: assert property (@(posedge sclk) disable iff (!por_n)
        $rose(wake_req) |-> !$past(to_n, 2) || !to_n || $past(wake_req)); // R5
endmodule

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    localparam int unsigned BASE = 16;

    logic wclk = 1'b0, sclk = 1'b0, sclk_run = 1'b1;
    logic por_n = 1'b0, cfg_en = 1'b1, ps_assign = 1'b0;
    logic [2:0] ps_ratio = 3'd0;
    logic clr_stb = 1'b0, sleep_stb = 1'b0, asleep = 1'b0;
    logic rst_req, wake_req, to_n;

    int checks = 0, errors = 0;
    int rst_cnt = 0, run_len = 0, max_run = 0;
    bit done = 1'b0;

    always #15 wclk = ~wclk;
    always begin
        #10;
        if (sclk_run) sclk = ~sclk;
    end

    wdog_top #(.BASE_CYC(BASE), .RATIO_W(3)) u0 (
        .wclk(wclk), .sclk(sclk), .por_n(por_n), .cfg_en(cfg_en),
        .ps_assign(ps_assign), .ps_ratio(ps_ratio), .clr_stb(clr_stb),
        .sleep_stb(sleep_stb), .asleep(asleep), .rst_req(rst_req),
        .wake_req(wake_req), .to_n(to_n)
    );

    always @(negedge sclk) begin
        if (rst_req) begin
            run_len = run_len + 1;
            if (run_len == 1) rst_cnt = rst_cnt + 1;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(posedge wclk);
        #1;
    endtask

    task automatic strobe(input bit sleep);
        @(negedge sclk);
        if (sleep) sleep_stb = 1'b1; else clr_stb = 1'b1;
        @(negedge sclk);
        sleep_stb = 1'b0;
        clr_stb   = 1'b0;
    endtask

    task automatic do_por(input bit en);
        cfg_en = en;
        por_n  = 1'b0;
        wcyc(3);
        por_n  = 1'b1;
        wcyc(6);
    endtask

    // One period window: none at P, exactly one by P+14
    task automatic period_check(input int p, input string req);
        int base;
        strobe(1'b0);
        wcyc(10);
        base = rst_cnt;
        strobe(1'b0);
        wcyc(p);
        chk(rst_cnt == base, req, rst_cnt - base, 0);
        wcyc(14);
        chk(rst_cnt == base + 1, req, rst_cnt - base, 1);
    endtask

    task automatic t_reset_state;
        chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
        chk(wake_req == 1'b0, "R1 wake_req", wake_req, 0);
        chk(to_n == 1'b1, "R1 to_n", to_n, 1);
    endtask

    task automatic t_run_timeout;
        int base;
        ps_assign = 1'b0;
        ps_ratio  = 3'd7;
        period_check(BASE, "R2");
        chk(to_n == 1'b0, "R6 to_n after timeout", to_n, 0);
        base = rst_cnt;
        wcyc(BASE);
        chk(rst_cnt == base + 1, "R9 second period", rst_cnt - base, 1);
        chk(max_run == 1, "R10 pulse width", max_run, 1);
        strobe(1'b0);
        wcyc(10);
        chk(to_n == 1'b1, "R6 to_n after clear", to_n, 1);
    endtask

    task automatic t_ratio(input logic [2:0] r);
        ps_assign = 1'b1;
        ps_ratio  = r;
        period_check(BASE << r, "R3");
    endtask

    task automatic t_clear_keeps;
        int base;
        ps_assign = 1'b1;
        ps_ratio  = 3'd2;
        strobe(1'b0);
        wcyc(10);
        base = rst_cnt;
        for (int i = 0; i < 8; i++) begin
            strobe(1'b0);
            wcyc(BASE * 2);
        end
        chk(rst_cnt == base, "R4 clears hold off reset", rst_cnt - base, 0);
        chk(to_n == 1'b1, "R4 status intact", to_n, 1);
    endtask

    task automatic t_sleep;
        int base;
        ps_assign = 1'b0;
        asleep    = 1'b1;
        wcyc(4);
        strobe(1'b1);
        wcyc(10);
        base = rst_cnt;
        chk(to_n == 1'b1, "R6 sleep strobe sets to_n", to_n, 1);
        wcyc(BASE * 3);
        chk(wake_req == 1'b1, "R5 wake raised", wake_req, 1);
        chk(rst_cnt == base, "R5 no reset asleep", rst_cnt - base, 0);
        chk(to_n == 1'b0, "R6 sleep timeout clears", to_n, 0);
        asleep = 1'b0;
        wcyc(4);
        strobe(1'b0);
        wcyc(10);
        chk(wake_req == 1'b0, "R5 wake dropped", wake_req, 0);
    endtask

    task automatic t_sclk_stop;
        int base;
        ps_assign = 1'b0;
        strobe(1'b0);
        wcyc(10);
        strobe(1'b0);
        repeat (6) @(negedge sclk);
        base = rst_cnt;
        sclk_run = 1'b0;
        wcyc(24);
        chk(rst_cnt == base, "R8 no pulse while stopped", rst_cnt - base, 0);
        sclk_run = 1'b1;
        repeat (6) @(negedge sclk);
        #1;
        chk(rst_cnt == base + 1, "R8 timeout seen after resume", rst_cnt - base, 1);
        chk(to_n == 1'b0, "R8 status after resume", to_n, 0);
    endtask

    task automatic t_disabled;
        int base;
        do_por(1'b0);
        base = rst_cnt;
        wcyc(BASE * 10);
        chk(rst_cnt == base, "R7 off no reset", rst_cnt - base, 0);
        chk(to_n == 1'b1, "R7 off status", to_n, 1);
        cfg_en = 1'b1;
        wcyc(BASE * 10);
        chk(rst_cnt == base, "R7 late enable ignored", rst_cnt - base, 0);
        do_por(1'b1);
        ps_assign = 1'b0;
        period_check(BASE, "R7 rearmed by reset");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wcyc(3);
        t_reset_state();
        por_n = 1'b1;
        wcyc(6);
        t_run_timeout();
        t_ratio(3'd0);
        t_ratio(3'd3);
        t_ratio(3'd7);
        t_clear_keeps();
        t_sleep();
        t_sclk_stop();
        t_disabled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule